// File: doc/BRIEF.md
# Fixed-Point Bilinear Gray-Pixel Interpolator

This block returns one 8-bit gray value for a sample point that lies between the pixel centres of an image held in an external byte-addressed buffer. The caller presents a fractional coordinate pair and the buffer's start address, and pulses `start`. The block works out where the pixel under the point lives and reads it. It also reads the right, lower-right and lower neighbours one at a time over a request/busy handshake. It then blends them with the fractional weights: two horizontal blends first, then one vertical blend.

The block skips every fetch after the first in two cases. The first is a sample that sits exactly on a pixel centre. The second is a base pixel on the outer border of the image. In both cases it returns the base pixel unchanged. The result stays on the output with its valid flag set until the next accepted start.

Top module: `bil_interp`

## Requirements
- R1: `x_in` is 15 bits and `y_in` is 14 bits. In each, the low 4 bits are the fraction and the upper bits are the integer column (0..1439) or row (0..899). The first read address is `base_addr + (row*1440 + col)*4`, computed modulo 2^25.
- R2: A full interpolation reads exactly four pixels in this order: base, right, lower-right, lower. Between reads the address changes by +4, then by +5760, then by -4.
- R3: While `mem_rd` is high and `mem_busy` is high, the block keeps `mem_rd` and `mem_addr` unchanged. It takes `mem_data` only on a clock edge where `mem_rd` is high and `mem_busy` is low.
- R4: When both 4-bit fractions are zero, only the base pixel is read, and the result equals that pixel.
- R5: When the integer column is 0 or 1439, or the integer row is 0 or 899, only the base pixel is read and the result equals it, whatever the fractions are.
- R6: Otherwise the result is e + round(fy*(f-e)/16), where e = p(r,c) + round(fx*(p(r,c+1)-p(r,c))/16) and f = p(r+1,c) + round(fx*(p(r+1,c+1)-p(r+1,c))/16). Here round(v/16) means floor((v+8)/16), and the result is clamped to 0..255.
- R7: An accepted `start` clears `pix_valid` on the next edge. `pix_valid` rises together with the result. After that, `pix_valid` and `pix_out` hold until the next accepted `start`.
- R8: While `rst_n` is low, `mem_rd` and `pix_valid` are low. This takes effect at once, with no clock edge needed, and afterwards the block is idle.
- R9: A `start` that arrives while an interpolation is in progress is ignored. The result still belongs to the coordinates latched first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; latches the coordinates and the base address when idle |
| x_in | input | 15 | Column coordinate: 11-bit integer part, 4-bit fraction |
| y_in | input | 14 | Row coordinate: 10-bit integer part, 4-bit fraction |
| base_addr | input | 25 | Byte address of pixel (0,0) in the buffer |
| mem_addr | output | 25 | Byte address of the pixel being read |
| mem_rd | output | 1 | Read request, held until the buffer is not busy |
| mem_busy | input | 1 | Buffer busy; low means `mem_data` is valid for `mem_addr` |
| mem_data | input | 8 | Gray byte returned by the buffer |
| pix_out | output | 8 | Interpolated gray value |
| pix_valid | output | 1 | `pix_out` holds the result of the last request |

## Verification
The assertions assume two things about the buffer. While `mem_rd` is high, it eventually drops `mem_busy`. Whenever `mem_busy` is low, `mem_data` belongs to the address on `mem_addr`. The address-step checks also assume that coordinates stay inside the image, so that no step wraps the 25-bit address. The stimulus keeps every integer part within 0..1439 and 0..899 and uses base addresses small enough that nothing wraps. The buffer model answers busy on a pseudo-random pattern and drives a junk byte whenever busy is high, so any capture taken in the wrong cycle shows up as a wrong result.

// File: rtl/bil_pkg.sv
package bil_pkg;
  localparam int PIX_W  = 8;
  localparam int FRAC_W = 4;
  localparam int NBR_N  = 4;
  localparam int IDX_W  = $clog2(NBR_N);
  localparam int DW     = PIX_W + FRAC_W + 2;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_BLEND} bil_state_t;

  // a + round(w*(b-a)/2^FRAC_W), clamped to the pixel range
  function automatic logic [PIX_W-1:0] lerp(input logic [PIX_W-1:0] a,
                                            input logic [PIX_W-1:0] b,
                                            input logic [FRAC_W-1:0] w);
    logic signed [DW-1:0] sa, sb, sw, diff, prod, sum;
    logic signed [DW-1:0] rnd;
    rnd  = DW'(1) <<< (FRAC_W - 1);
    sa   = signed'({{(FRAC_W+2){1'b0}}, a});
    sb   = signed'({{(FRAC_W+2){1'b0}}, b});
    sw   = signed'({{(PIX_W+2){1'b0}}, w});
    diff = sb - sa;
    prod = diff * sw;
    sum  = sa + ((prod + rnd) >>> FRAC_W);
    if (sum[DW-1])
      lerp = '0;
    else if (|sum[DW-2:PIX_W])
      lerp = '1;
    else
      lerp = sum[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/bil_addr_gen.sv
module bil_addr_gen #(
  parameter int IMG_W     = 1440,
  parameter int XI_W      = 11,
  parameter int YI_W      = 10,
  parameter int ADDR_W    = 25,
  parameter int PIX_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [XI_W-1:0]   col,
  input  logic [YI_W-1:0]   row,
  input  logic              advance,
  input  logic [1:0]        idx,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] STEP_X = ADDR_W'(PIX_BYTES);
  localparam logic [ADDR_W-1:0] STEP_Y = ADDR_W'(IMG_W * PIX_BYTES);

  logic [ADDR_W-1:0] lin;
  assign lin = ADDR_W'(row) * ADDR_W'(IMG_W) + ADDR_W'(col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= base + lin * STEP_X;
    else if (advance) begin
      case (idx)
        2'd0:    addr <= addr + STEP_X;
        2'd1:    addr <= addr + STEP_Y;
        2'd2:    addr <= addr - STEP_X;
        default: addr <= addr;
      endcase
    end
  end
endmodule

// File: rtl/bil_ctrl.sv
module bil_ctrl
  import bil_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             skip,
  input  logic             mem_busy,
  output logic             load,
  output logic             fetching,
  output logic             fetch_ack,
  output logic             advance,
  output logic             blend_now,
  output logic             idle,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBR_N - 1);

  bil_state_t state_q;

  assign idle      = (state_q == ST_IDLE);
  assign fetching  = (state_q == ST_FETCH);
  assign blend_now = (state_q == ST_BLEND);
  assign load      = idle && start;
  assign fetch_ack = fetching && !mem_busy;
  assign advance   = fetch_ack && !skip && (idx != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_FETCH;
          idx     <= '0;
        end
        ST_FETCH: if (fetch_ack) begin
          if (skip)
            state_q <= ST_IDLE;
          else if (idx == LAST)
            state_q <= ST_BLEND;
          else
            idx <= idx + 1'b1;
        end
        ST_BLEND: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bil_blend.sv
module bil_blend
  import bil_pkg::*;
(
  input  logic [PIX_W-1:0]  p_tl,
  input  logic [PIX_W-1:0]  p_tr,
  input  logic [PIX_W-1:0]  p_br,
  input  logic [PIX_W-1:0]  p_bl,
  input  logic [FRAC_W-1:0] fx,
  input  logic [FRAC_W-1:0] fy,
  output logic [PIX_W-1:0]  res
);
  logic [PIX_W-1:0] top_mix, bot_mix;
  assign top_mix = lerp(p_tl, p_tr, fx);
  assign bot_mix = lerp(p_bl, p_br, fx);
  assign res     = lerp(top_mix, bot_mix, fy);
endmodule

// File: rtl/bil_interp.sv
module bil_interp
  import bil_pkg::*;
#(
  parameter int IMG_W     = 1440,
  parameter int IMG_H     = 900,
  parameter int XI_W      = 11,
  parameter int YI_W      = 10,
  parameter int ADDR_W    = 25,
  parameter int PIX_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [XI_W+FRAC_W-1:0] x_in,
  input  logic [YI_W+FRAC_W-1:0] y_in,
  input  logic [ADDR_W-1:0]      base_addr,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic                   mem_rd,
  input  logic                   mem_busy,
  input  logic [PIX_W-1:0]       mem_data,
  output logic [PIX_W-1:0]       pix_out,
  output logic                   pix_valid
);
  localparam int X_W = XI_W + FRAC_W;
  localparam int Y_W = YI_W + FRAC_W;

  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;
  logic [XI_W-1:0] col_w;
  logic [YI_W-1:0] row_w;
  logic [FRAC_W-1:0] fx_w, fy_w;

  // named internal events, used by the checker
  logic             load_w, fetch_ack, advance_w, blend_now, in_idle, skip_blend;
  logic [IDX_W-1:0] fetch_idx;
  logic [PIX_W-1:0] blend_res;
  logic [PIX_W-1:0] slot [NBR_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else if (load_w) begin
      x_q <= x_in;
      y_q <= y_in;
    end
  end

  assign col_w = x_q[X_W-1:FRAC_W];
  assign row_w = y_q[Y_W-1:FRAC_W];
  assign fx_w  = x_q[FRAC_W-1:0];
  assign fy_w  = y_q[FRAC_W-1:0];

  // base pixel only: exact grid point or border pixel
  assign skip_blend = ((fx_w == '0) && (fy_w == '0))
                    || (col_w == '0) || (row_w == '0)
                    || (col_w == XI_W'(IMG_W - 1))
                    || (row_w == YI_W'(IMG_H - 1));

  bil_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .skip      (skip_blend),
    .mem_busy  (mem_busy),
    .load      (load_w),
    .fetching  (mem_rd),
    .fetch_ack (fetch_ack),
    .advance   (advance_w),
    .blend_now (blend_now),
    .idle      (in_idle),
    .idx       (fetch_idx)
  );

  // the load uses the live inputs, since the latch happens on the same edge
  bil_addr_gen #(
    .IMG_W(IMG_W), .XI_W(XI_W), .YI_W(YI_W),
    .ADDR_W(ADDR_W), .PIX_BYTES(PIX_BYTES)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_w),
    .base    (base_addr),
    .col     (x_in[X_W-1:FRAC_W]),
    .row     (y_in[Y_W-1:FRAC_W]),
    .advance (advance_w),
    .idx     (fetch_idx),
    .addr    (mem_addr)
  );

  for (genvar k = 0; k < NBR_N; k++) begin : g_slot
    logic [PIX_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (fetch_ack && (fetch_idx == IDX_W'(k)))
        q <= mem_data;
    end
    assign slot[k] = q;
  end

  bil_blend u_blend (
    .p_tl (slot[0]),
    .p_tr (slot[1]),
    .p_br (slot[2]),
    .p_bl (slot[3]),
    .fx   (fx_w),
    .fy   (fy_w),
    .res  (blend_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out   <= '0;
      pix_valid <= 1'b0;
    end else if (load_w) begin
      pix_valid <= 1'b0;
    end else if (fetch_ack && skip_blend) begin
      pix_out   <= mem_data;
      pix_valid <= 1'b1;
    end else if (blend_now) begin
      pix_out   <= blend_res;
      pix_valid <= 1'b1;
    end
  end
endmodule

// File: rtl/bil_interp_chk.sv
module bil_interp_chk #(
  parameter int IMG_W     = 1440,
  parameter int ADDR_W    = 25,
  parameter int PIX_BYTES = 4,
  parameter int PIX_W     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_rd,
  input logic              mem_busy,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pix_valid,
  input logic [PIX_W-1:0]  pix_out,
  input logic              fetch_ack,
  input logic [1:0]        fetch_idx,
  input logic              skip_blend,
  input logic              in_idle
);
  localparam logic [ADDR_W-1:0] SX = ADDR_W'(PIX_BYTES);
  localparam logic [ADDR_W-1:0] SY = ADDR_W'(IMG_W * PIX_BYTES);

  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && mem_busy |=> mem_rd && $stable(mem_addr));

  p_step_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && !skip_blend && fetch_idx == 2'd0 |=> mem_addr == $past(mem_addr) + SX);

  p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && !skip_blend && fetch_idx == 2'd1 |=> mem_addr == $past(mem_addr) + SY);

  p_step_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && !skip_blend && fetch_idx == 2'd2 |=> mem_addr == $past(mem_addr) - SX);

  p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && skip_blend |=> pix_valid && !mem_rd);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !start |=> pix_valid && $stable(pix_out));

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start && in_idle |=> !pix_valid && mem_rd);

  p_late_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && mem_rd && mem_busy |=> mem_rd && $stable(mem_addr));

  p_rd_valid_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && pix_valid));
endmodule

bind bil_interp bil_interp_chk #(
  .IMG_W(IMG_W), .ADDR_W(ADDR_W), .PIX_BYTES(PIX_BYTES), .PIX_W(bil_pkg::PIX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .mem_rd     (mem_rd),
  .mem_busy   (mem_busy),
  .mem_addr   (mem_addr),
  .pix_valid  (pix_valid),
  .pix_out    (pix_out),
  .fetch_ack  (fetch_ack),
  .fetch_idx  (fetch_idx),
  .skip_blend (skip_blend),
  .in_idle    (in_idle)
);

// File: tb/sim_bil_interp.sv
`timescale 1ns/1ps
module sim_bil_interp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [14:0] x_in = '0;
  logic [13:0] y_in = '0;
  logic [24:0] base_addr = '0;
  logic [24:0] mem_addr;
  logic        mem_rd;
  logic        mem_busy = 1'b0;
  logic [7:0]  mem_data = '0;
  logic [7:0]  pix_out;
  logic        pix_valid;

  int checks = 0;
  int errors = 0;
  int unsigned lcg = 32'h1234_5678;
  int busy_mode = 1;
  logic [24:0] got_addr[$];
  logic        prev_wait = 1'b0;
  logic [24:0] prev_addr = '0;

  always #10 clk = ~clk;

  bil_interp u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .base_addr(base_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_busy(mem_busy), .mem_data(mem_data), .pix_out(pix_out),
    .pix_valid(pix_valid)
  );

  function automatic int pix_of(input logic [24:0] a);
    int w;
    w = int'(a >> 2);
    return ((w * 37) ^ ((w >> 7) * 11) ^ (w >> 3)) & 255;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // buffer model: pseudo-random busy, junk data while busy
  always @(negedge clk) begin
    logic nb;
    lcg = lcg * 32'd1103515245 + 32'd12345;
    nb = (busy_mode != 0) && (((lcg >> 16) % 3) != 0);
    if (rst_n && prev_wait)
      chk(mem_rd && (mem_addr == prev_addr), "R3", "request held while busy",
          int'(mem_addr), int'(prev_addr));
    mem_busy = nb;
    mem_data = nb ? 8'hA5 ^ 8'(lcg >> 8) : 8'(pix_of(mem_addr));
    if (mem_rd && !nb) got_addr.push_back(mem_addr);
    prev_wait = mem_rd && nb;
    prev_addr = mem_addr;
  end

  task automatic run(input int col, input int fx, input int row, input int fy,
                     input int base, input bit poke);
    int a0, e, f, r, n, p00, p01, p11, p10;
    bit skip;
    int exp_addr[$];
    string req;
    a0 = base + (row * 1440 + col) * 4;
    skip = (fx == 0 && fy == 0) || col == 0 || row == 0 || col == 1439 || row == 899;
    p00 = pix_of(25'(a0));
    if (skip) begin
      exp_addr = '{a0};
      r = p00;
      req = (fx == 0 && fy == 0) ? "R4" : "R5";
    end else begin
      exp_addr = '{a0, a0 + 4, a0 + 4 + 5760, a0 + 5760};
      p01 = pix_of(25'(a0 + 4));
      p11 = pix_of(25'(a0 + 5764));
      p10 = pix_of(25'(a0 + 5760));
      e = (16 * p00 + fx * (p01 - p00) + 8) / 16;
      f = (16 * p10 + fx * (p11 - p10) + 8) / 16;
      r = (16 * e + fy * (f - e) + 8) / 16;
      if (r > 255) r = 255;
      req = "R6";
    end
    @(negedge clk);
    got_addr.delete();
    x_in = 15'(col * 16 + fx);
    y_in = 14'(row * 16 + fy);
    base_addr = 25'(base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!pix_valid, "R7", "valid cleared by start", int'(pix_valid), 0);
    if (poke) begin
      x_in = 15'((col + 7) * 16 + 3);
      base_addr = 25'(base + 64);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!pix_valid && n < 500) begin
      @(negedge clk);
      n++;
    end
    chk(pix_valid, "R7", "valid rose", int'(pix_valid), 1);
    chk(int'(pix_out) == r, poke ? "R9" : req, "result", int'(pix_out), r);
    chk(got_addr.size() == exp_addr.size(), skip ? req : "R2", "read count",
        got_addr.size(), exp_addr.size());
    for (int i = 0; i < exp_addr.size() && i < got_addr.size(); i++)
      chk(int'(got_addr[i]) == exp_addr[i], i == 0 ? "R1" : "R2", "read address",
          int'(got_addr[i]), exp_addr[i]);
    repeat (3) @(negedge clk);
    chk(pix_valid && int'(pix_out) == r, "R7", "result held", int'(pix_out), r);
  endtask

  initial begin
    #4_000_000;
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #35;
    chk(!mem_rd && !pix_valid, "R8", "outputs low in reset", int'({mem_rd, pix_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pix_valid && !mem_rd, "R8", "idle after reset", int'({mem_rd, pix_valid}), 0);

    run(100, 5, 50, 11, 0, 1'b0);
    run(700, 15, 400, 15, 32'h10000, 1'b0);
    run(3, 0, 7, 9, 0, 1'b0);
    run(1200, 8, 898, 0, 32'h200, 1'b0);
    run(55, 0, 66, 0, 0, 1'b0);
    run(0, 7, 300, 4, 0, 1'b0);
    run(1439, 12, 300, 4, 0, 1'b0);
    run(500, 3, 0, 9, 32'h40, 1'b0);
    run(500, 3, 899, 9, 0, 1'b0);
    busy_mode = 0;
    run(1438, 1, 898, 14, 32'h1000, 1'b0);
    run(1, 10, 1, 6, 0, 1'b0);
    busy_mode = 1;
    run(321, 9, 123, 2, 0, 1'b1);
    run(800, 4, 600, 13, 32'h3000, 1'b0);

    // asynchronous reset in mid-sequence
    @(negedge clk);
    x_in = 15'(200 * 16 + 5);
    y_in = 14'(200 * 16 + 5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #3 rst_n = 1'b0;
    #1 chk(!mem_rd && !pix_valid, "R8", "async reset clears", int'({mem_rd, pix_valid}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_rd && !pix_valid, "R8", "idle after async reset", int'({mem_rd, pix_valid}), 0);
    run(640, 6, 480, 10, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule